// File: doc/BRIEF.md
# Locality Ownership Arbiter

This block decides which of several localities owns a shared command interface. Each locality has an access byte of its own. Software writes command bits into that byte, and reads it back to learn its standing. The block handles four commands: ask for ownership, force ownership away from a lower-numbered owner, give ownership up, and acknowledge a past seizure. It keeps one request flag and one seized flag per locality, and it records the current owner. The owner is presented on two dedicated outputs so that neighbouring logic can gate the data path.

The highest index (4 with the defaults) is meant for a hardware-driven path. Indices 0 to 3 are used by software. The arbiter itself treats every in-range index by the same rules. A read is combinational: the byte for the index on `loc_idx` appears on `rd_data` in the same cycle. A write is taken on the rising clock edge while `wr_en` is high. When an owner gives ownership up, the next owner is chosen in that same edge.

Top module: `locality_arbiter`

## Requirements
- R1: After reset, and whenever no locality owns the interface and none has a request or seized flag, every in-range locality reads 0x81, and `active_valid` is 0.
- R2: A request (bit 1) while nobody owns the interface grants ownership at the next edge. The requester then reads the active bit (bit 5) as 1, and its request bit stays clear.
- R3: A request from a non-owner while another locality owns the interface sets that locality's request bit (bit 1). The owner then reads the pending bit (bit 2) as 1.
- R4: A locality reads the pending bit (bit 2) as 1 exactly when some other locality has its request bit set.
- R5: A seize (bit 3) from a locality numbered at or below the current owner, or while nobody owns the interface, changes nothing.
- R6: A seize from a locality numbered above the owner takes ownership at the next edge. The old owner loses the active bit and reads the been-seized bit (bit 4) as 1.
- R7: Writing a 1 to bit 4 clears the writing locality's been-seized bit.
- R8: When the owner writes bit 5, it gives ownership up. In the same edge ownership moves to the highest-numbered locality with its request bit set, and that locality's request bit is cleared.
- R9: If the owner gives ownership up while no request is outstanding, `active_valid` falls to 0.
- R10: An index at or above the number of localities reads 0xFF, and a write to it changes no state.
- R11: `active_valid` and `active_loc` report the owner, and they change only on a write.
- R12: Within one written byte, only one command acts. Give-up (bit 5) wins over seize (bit 3), and seize wins over request (bit 1). A seize that has no effect still blocks the request in the same byte. Bit 4 is acted on independently of the other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the access byte of `loc_idx` |
| loc_idx | input | 3 | Locality addressed by both the read and the write |
| wr_data | input | 8 | Command byte being written |
| rd_data | output | 8 | Access byte of locality `loc_idx` (0xFF when out of range) |
| active_valid | output | 1 | Some locality owns the interface |
| active_loc | output | 3 | Index of the owning locality |

## Verification
The bench builds the arbiter with its default of five localities on a three-bit index. Index 4 can therefore be driven like any other, and indices 5 to 7 test the out-of-range path. The command sequence builds up three outstanding requests, so that pending flags, the handoff order on release and seizures in both directions can all be seen. Bytes that set several command bits at once check the priority rule.

// File: rtl/lar_pkg.sv
package lar_pkg;

    localparam int unsigned B_VALID  = 7;
    localparam int unsigned B_ACTIVE = 5;
    localparam int unsigned B_SEIZED = 4;
    localparam int unsigned B_SEIZE  = 3;
    localparam int unsigned B_PEND   = 2;
    localparam int unsigned B_REQ    = 1;
    localparam int unsigned B_EST    = 0;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_REQUEST,
        OP_SEIZE,
        OP_RELEASE
    } op_e;

    typedef struct packed {
        op_e  op;
        logic clr_seized;
    } cmd_t;

    typedef struct packed {
        logic owner;
        logic seized;
        logic asking;
        logic pending;
    } view_t;

    // One command per byte: release beats seize, seize beats request.
    function automatic cmd_t decode_cmd(input logic [7:0] d);
        cmd_t c;
        c.clr_seized = d[B_SEIZED];
        if (d[B_ACTIVE])      c.op = OP_RELEASE;
        else if (d[B_SEIZE])  c.op = OP_SEIZE;
        else if (d[B_REQ])    c.op = OP_REQUEST;
        else                  c.op = OP_NONE;
        return c;
    endfunction

    function automatic logic [7:0] pack_access(input view_t v);
        logic [7:0] b;
        b           = '0;
        b[B_VALID]  = 1'b1;
        b[B_EST]    = 1'b1;
        b[B_ACTIVE] = v.owner;
        b[B_SEIZED] = v.seized;
        b[B_REQ]    = v.asking;
        b[B_PEND]   = v.pending;
        return b;
    endfunction

endpackage

// File: rtl/lar_ctrl.sv
module lar_ctrl
    import lar_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [LOC_W-1:0]   wr_loc,
    input  cmd_t               cmd,
    output logic [NUM_LOC-1:0] req_q,
    output logic [NUM_LOC-1:0] seized_q,
    output logic               act_vld_q,
    output logic [LOC_W-1:0]   act_loc_q
);

    localparam logic [LOC_W:0] LIMIT = (LOC_W+1)'(NUM_LOC);

    logic [NUM_LOC-1:0] req_n;
    logic [NUM_LOC-1:0] seized_n;
    logic               act_vld_n;
    logic [LOC_W-1:0]   act_loc_n;
    logic [LOC_W-1:0]   pick;
    logic               loc_ok;
    logic               is_owner;

    assign loc_ok   = ({1'b0, wr_loc} < LIMIT);
    assign is_owner = act_vld_q && (act_loc_q == wr_loc);

    always_comb begin
        req_n     = req_q;
        seized_n  = seized_q;
        act_vld_n = act_vld_q;
        act_loc_n = act_loc_q;
        pick      = '0;
        if (wr_en && loc_ok) begin
            if (cmd.clr_seized) seized_n[wr_loc] = 1'b0;
            unique case (cmd.op)
                OP_RELEASE: begin
                    req_n[wr_loc] = 1'b0;
                    if (is_owner) begin
                        act_vld_n = 1'b0;
                        for (int i = 0; i < NUM_LOC; i++) begin
                            if (req_n[i]) pick = LOC_W'(i);
                        end
                        if (|req_n) begin
                            act_vld_n   = 1'b1;
                            act_loc_n   = pick;
                            req_n[pick] = 1'b0;
                        end
                    end
                end
                OP_SEIZE: begin
                    if (act_vld_q && (wr_loc > act_loc_q)) begin
                        seized_n[act_loc_q] = 1'b1;
                        act_loc_n           = wr_loc;
                        req_n[wr_loc]       = 1'b0;
                    end
                end
                OP_REQUEST: begin
                    if (!act_vld_q) begin
                        act_vld_n = 1'b1;
                        act_loc_n = wr_loc;
                    end else if (!is_owner) begin
                        req_n[wr_loc] = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q     <= '0;
            seized_q  <= '0;
            act_vld_q <= 1'b0;
            act_loc_q <= '0;
        end else begin
            req_q     <= req_n;
            seized_q  <= seized_n;
            act_vld_q <= act_vld_n;
            act_loc_q <= act_loc_n;
        end
    end

endmodule

// File: rtl/lar_view.sv
module lar_view
    import lar_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 3,
    parameter int IDX     = 0
) (
    input  logic [NUM_LOC-1:0] req_q,
    input  logic [NUM_LOC-1:0] seized_q,
    input  logic               act_vld_q,
    input  logic [LOC_W-1:0]   act_loc_q,
    output logic [7:0]         access
);

    localparam logic [LOC_W-1:0]   ME     = LOC_W'(IDX);
    localparam logic [NUM_LOC-1:0] OTHERS = ~(NUM_LOC'(1) << IDX);

    view_t v;

    always_comb begin
        v.owner   = act_vld_q && (act_loc_q == ME);
        v.seized  = seized_q[IDX];
        v.asking  = req_q[IDX];
        v.pending = |(req_q & OTHERS);
        access    = pack_access(v);
    end

endmodule

// File: rtl/locality_arbiter.sv
module locality_arbiter
    import lar_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [LOC_W-1:0] loc_idx,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data,
    output logic             active_valid,
    output logic [LOC_W-1:0] active_loc
);

    localparam logic [LOC_W:0] LIMIT = (LOC_W+1)'(NUM_LOC);

    logic [NUM_LOC-1:0] req_q;
    logic [NUM_LOC-1:0] seized_q;
    logic               act_vld_q;
    logic [LOC_W-1:0]   act_loc_q;
    logic [7:0]         acc [NUM_LOC];
    cmd_t               cmd;

    assign cmd = decode_cmd(wr_data);

    lar_ctrl #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_loc    (loc_idx),
        .cmd       (cmd),
        .req_q     (req_q),
        .seized_q  (seized_q),
        .act_vld_q (act_vld_q),
        .act_loc_q (act_loc_q)
    );

    for (genvar g = 0; g < NUM_LOC; g++) begin : g_view
        lar_view #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .IDX(g)) u_view (
            .req_q     (req_q),
            .seized_q  (seized_q),
            .act_vld_q (act_vld_q),
            .act_loc_q (act_loc_q),
            .access    (acc[g])
        );
    end

    always_comb begin
        if ({1'b0, loc_idx} < LIMIT) rd_data = acc[loc_idx];
        else                          rd_data = 8'hFF;
    end

    assign active_valid = act_vld_q;
    assign active_loc   = act_loc_q;

endmodule

// File: rtl/lar_checker.sv
module lar_checker #(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [LOC_W-1:0] loc_idx,
    input logic [7:0]       wr_data,
    input logic [7:0]       rd_data,
    input logic             active_valid,
    input logic [LOC_W-1:0] active_loc
);

    localparam logic [LOC_W:0] LIMIT = (LOC_W+1)'(NUM_LOC);

    logic in_rng;
    assign in_rng = ({1'b0, loc_idx} < LIMIT);

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !active_valid);

    // R2
    idle_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && in_rng && !active_valid && wr_data[1] && !wr_data[3] && !wr_data[5])
        |=> (active_valid && active_loc == $past(loc_idx)));

    // R5
    low_seize_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && in_rng && active_valid && wr_data[3] && !wr_data[5] && loc_idx <= active_loc)
        |=> (active_valid && $stable(active_loc)));

    // R6
    high_seize_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && in_rng && active_valid && wr_data[3] && !wr_data[5] && loc_idx > active_loc)
        |=> (active_valid && active_loc == $past(loc_idx)));

    // R10
    range_rd_chk: assert property (@(posedge clk) disable iff (rst)
        !in_rng |-> rd_data == 8'hFF);

    // R10
    range_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !in_rng) |=> ($stable(active_valid) && $stable(active_loc)));

    // R11
    quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(active_valid) && $stable(active_loc)));

endmodule

bind locality_arbiter lar_checker #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_lar_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .loc_idx      (loc_idx),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .active_valid (active_valid),
    .active_loc   (active_loc)
);

// File: tb/locality_arbiter_bench.sv
module locality_arbiter_bench;

    localparam int NUM_LOC = 5;
    localparam int LOC_W   = 3;

    typedef struct packed {
        logic [2:0] wl;
        logic [7:0] wd;
        logic [2:0] rl;
        logic [7:0] exp_rd;
        logic       exp_av;
        logic [2:0] exp_al;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 20;
    // A row with wd == 0 performs no write; exp_al is checked only when exp_av is 1.
    localparam vec_t VEC [NV] = '{
        '{3'd0, 8'h02, 3'd0, 8'hA1, 1'b1, 3'd0, 4'd2},   // R2 idle grant
        '{3'd2, 8'h02, 3'd2, 8'h83, 1'b1, 3'd0, 4'd3},   // R3 request queued
        '{3'd0, 8'h00, 3'd0, 8'hA5, 1'b1, 3'd0, 4'd3},   // R3 owner sees pending
        '{3'd1, 8'h02, 3'd1, 8'h87, 1'b1, 3'd0, 4'd4},   // R4 waiter sees pending
        '{3'd3, 8'h08, 3'd0, 8'h95, 1'b1, 3'd3, 4'd6},   // R6 seize from above
        '{3'd0, 8'h00, 3'd3, 8'hA5, 1'b1, 3'd3, 4'd6},   // R6 new owner
        '{3'd2, 8'h08, 3'd2, 8'h87, 1'b1, 3'd3, 4'd5},   // R5 seize from below
        '{3'd0, 8'h10, 3'd0, 8'h85, 1'b1, 3'd3, 4'd7},   // R7 clear seized
        '{3'd3, 8'h20, 3'd2, 8'hA5, 1'b1, 3'd2, 4'd8},   // R8 handoff to highest
        '{3'd0, 8'h00, 3'd1, 8'h83, 1'b1, 3'd2, 4'd8},   // R8 remaining request
        '{3'd2, 8'h20, 3'd1, 8'hA1, 1'b1, 3'd1, 4'd8},   // R8 last handoff
        '{3'd1, 8'h20, 3'd1, 8'h81, 1'b0, 3'd0, 4'd9},   // R9 release to idle
        '{3'd0, 8'h00, 3'd4, 8'h81, 1'b0, 3'd0, 4'd1},   // R1 idle index 4
        '{3'd4, 8'h02, 3'd4, 8'hA1, 1'b1, 3'd4, 4'd11},  // R11 owner index 4
        '{3'd4, 8'h3A, 3'd4, 8'h81, 1'b0, 3'd0, 4'd12},  // R12 release wins
        '{3'd2, 8'h0A, 3'd2, 8'h81, 1'b0, 3'd0, 4'd12},  // R12 seize blocks request
        '{3'd5, 8'h02, 3'd5, 8'hFF, 1'b0, 3'd0, 4'd10},  // R10 out of range
        '{3'd0, 8'h02, 3'd0, 8'hA1, 1'b1, 3'd0, 4'd2},   // R2 grant again
        '{3'd6, 8'h20, 3'd0, 8'hA1, 1'b1, 3'd0, 4'd10},  // R10 write ignored
        '{3'd0, 8'h20, 3'd0, 8'h81, 1'b0, 3'd0, 4'd9}    // R9 idle again
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [LOC_W-1:0] loc_idx = '0;
    logic [7:0]       wr_data = '0;
    logic [7:0]       rd_data;
    logic             active_valid;
    logic [LOC_W-1:0] active_loc;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    locality_arbiter #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_locality_arbiter (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .loc_idx      (loc_idx),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .active_valid (active_valid),
        .active_loc   (active_loc)
    );

    task automatic put(input logic [2:0] l, input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        loc_idx = l;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic look(input logic [2:0] l, input logic [7:0] er, input logic eav,
                        input logic [2:0] eal, input int rq);
        wr_en   = 1'b0;
        loc_idx = l;
        #1;
        checks++;
        if (rd_data !== er || active_valid !== eav || (eav && active_loc !== eal)) begin
            fails++;
            $display("FAIL R%0d loc %0d: got rd=%02h av=%0b al=%0d, want rd=%02h av=%0b al=%0d",
                     rq, l, rd_data, active_valid, active_loc, er, eav, eal);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1: every locality idle after reset
        for (int i = 0; i < NUM_LOC; i++) look(3'(i), 8'h81, 1'b0, 3'd0, 1);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k].wd != 8'h00) put(VEC[k].wl, VEC[k].wd);
            else @(negedge clk);
            look(VEC[k].rl, VEC[k].exp_rd, VEC[k].exp_av, VEC[k].exp_al, int'(VEC[k].rq));
        end

        // R4: two waiters, each sees the other's request
        put(3'd1, 8'h02);
        put(3'd3, 8'h02);
        put(3'd2, 8'h02);
        look(3'd3, 8'h87, 1'b1, 3'd1, 4);
        look(3'd2, 8'h87, 1'b1, 3'd1, 4);
        // R8: highest requester (3) wins over 2
        put(3'd1, 8'h20);
        look(3'd3, 8'hA5, 1'b1, 3'd3, 8);
        // R5: owner seizing itself changes nothing
        put(3'd3, 8'h08);
        look(3'd3, 8'hA5, 1'b1, 3'd3, 5);
        // R3: owner re-requesting does not set its own request bit
        put(3'd3, 8'h02);
        look(3'd3, 8'hA5, 1'b1, 3'd3, 3);
        // R1: reset mid-operation returns to idle
        do_reset();
        look(3'd2, 8'h81, 1'b0, 3'd0, 1);
        look(3'd3, 8'h81, 1'b0, 3'd0, 1);
        // R10: index 7 reads 0xFF
        look(3'd7, 8'hFF, 1'b0, 3'd0, 10);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule